// File: doc/BRIEF.md
# Character-Cell Video Raster Generator

This block produces a complete video raster from a character screen. A pair of free-running counters walks the frame. Each visible pixel is mapped to a character cell, and the block looks up that cell's character code and two colour indices in an external character memory. It then fetches one row of the glyph from an external glyph ROM, picks either the foreground or the background index from the glyph bit, and converts the index to 24-bit colour through a 16-entry palette. Horizontal sync, vertical sync and blank leave the block on the same clock as the colour they belong to.

Glyphs are 16 pixels wide and 32 pixels tall. The rotated mode turns every glyph a quarter turn to the left, so each screen cell becomes 32 pixels wide and 16 pixels tall. The mode input takes effect only at frame boundaries, so a frame is never drawn in two orientations. The default timing gives 800x600 visible pixels with a 50 MHz pixel clock, 1040 clocks per line and 666 lines per frame, which is about 72 frames per second.

Top module: `text_raster_gen`

## Requirements
- R1: A line lasts H_ACTIVE+H_FP+H_SYNC+H_BP clocks and a frame lasts V_ACTIVE+V_FP+V_SYNC+V_BP lines (defaults 800/56/120/64 and 600/37/6/23). Each frame shows exactly V_ACTIVE lines of H_ACTIVE visible pixels, and the first visible pixel comes (V_SYNC+V_BP) lines after vsync_o rises.
- R2: hsync_o is high for H_SYNC clocks, starting H_FP clocks after the last visible pixel of a line. vsync_o is high for V_SYNC whole lines, starting V_FP lines after the last visible line. Both syncs are active high and are only asserted while blank_o is high.
- R3: blank_o is high for every pixel outside the visible area, and rgb_o is zero whenever blank_o is high.
- R4: In normal mode a pixel (x,y) belongs to cell column x/16 and cell row y/32. The character memory address is row*64+col (row in bits 11:6, column in bits 5:0), and read data arrives one clock after the address.
- R5: A character word holds the code in bits 7:0, the foreground index in bits 11:8 and the background index in bits 15:12.
- R6: The glyph ROM address is {code, glyph_row} with the glyph row in bits 4:0. Data arrives one clock later, and bit 15-c holds glyph column c (bit 15 is the leftmost pixel). In normal mode the glyph row is y%32 and the glyph column is x%16.
- R7: A pixel takes the foreground index when its glyph bit is 1 and the background index when it is 0.
- R8: Writing with pal_we_i stores entry pal_waddr_i. A visible pixel of index i shows bits 31:8 of the last word written to entry i. Bits 7:0 of a palette word have no effect on the output.
- R9: In rotated mode a pixel (x,y) belongs to cell column x/32 and cell row y/16, with the same address layout as R4. The glyph row is x%32 and the glyph column is 15-(y%16).
- R10: rotate_i is sampled only on the last clock of a frame. A change made in the middle of a frame leaves the rest of that frame unchanged and applies from the first pixel of the next frame.
- R11: During reset blank_o is 1, hsync_o, vsync_o and rgb_o are 0, all palette entries are zero and rotation is off. After reset the raster starts at the first visible pixel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Pixel clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rotate_i | input | 1 | Selects quarter-turn-left glyph orientation |
| char_addr_o | output | 12 | Character memory read address |
| char_data_i | input | 16 | Character memory read data |
| glyph_addr_o | output | 13 | Glyph ROM read address |
| glyph_data_i | input | 16 | Glyph ROM row data |
| pal_we_i | input | 1 | Palette write strobe |
| pal_waddr_i | input | 4 | Palette entry to write |
| pal_wdata_i | input | 32 | Palette word, colour in bits 31:8 |
| hsync_o | output | 1 | Horizontal sync, active high |
| vsync_o | output | 1 | Vertical sync, active high |
| blank_o | output | 1 | High outside the visible area |
| rgb_o | output | 24 | Pixel colour |

## Verification
The hardest situation to reach is a change of rotate_i in the middle of a visible frame. The partly drawn frame has to finish in the old orientation and the next frame has to start in the new one, and only a sampling point at the frame wrap makes both come out right. The bench gets there by waiting for the start of a frame's visible region and toggling rotate_i a few hundred clocks into it, while a parallel scan checks every pixel of that frame against the old orientation. It then scans the following frame against the new one. A reduced raster size keeps these multi-frame scans short, while the default parameters keep the full 800x600 timing.

// File: rtl/text_raster_pkg.sv
package text_raster_pkg;
  typedef struct packed {
    logic hs;
    logic vs;
    logic blank;
  } sync_t;
endpackage

// File: rtl/raster_timing.sv
module raster_timing
  import text_raster_pkg::*;
#(
  parameter int H_ACTIVE = 800,
  parameter int H_FP     = 56,
  parameter int H_SYNC   = 120,
  parameter int H_BP     = 64,
  parameter int V_ACTIVE = 600,
  parameter int V_FP     = 37,
  parameter int V_SYNC   = 6,
  parameter int V_BP     = 23,
  localparam int HT = H_ACTIVE + H_FP + H_SYNC + H_BP,
  localparam int VT = V_ACTIVE + V_FP + V_SYNC + V_BP,
  localparam int HW = $clog2(HT),
  localparam int VW = $clog2(VT)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          rotate_i,
  output logic [HW-1:0] h_o,
  output logic [VW-1:0] v_o,
  output sync_t         sync_o,
  output logic          rot_o,
  output logic          frame_end_o
);
  localparam logic [HW-1:0] H_LAST   = HW'(HT - 1);
  localparam logic [VW-1:0] V_LAST   = VW'(VT - 1);
  localparam logic [HW-1:0] HS_START = HW'(H_ACTIVE + H_FP);
  localparam logic [HW-1:0] HS_END   = HW'(H_ACTIVE + H_FP + H_SYNC);
  localparam logic [VW-1:0] VS_START = VW'(V_ACTIVE + V_FP);
  localparam logic [VW-1:0] VS_END   = VW'(V_ACTIVE + V_FP + V_SYNC);

  logic [HW-1:0] h_q;
  logic [VW-1:0] v_q;
  logic          rot_q;
  logic          line_end;

  assign line_end    = (h_q == H_LAST);
  assign frame_end_o = line_end && (v_q == V_LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      h_q   <= '0;
      v_q   <= '0;
      rot_q <= 1'b0;
    end else begin
      if (line_end) begin
        h_q <= '0;
        v_q <= (v_q == V_LAST) ? '0 : v_q + VW'(1);
      end else begin
        h_q <= h_q + HW'(1);
      end
      // orientation only changes across the frame wrap
      if (frame_end_o) rot_q <= rotate_i;
    end
  end

  assign h_o          = h_q;
  assign v_o          = v_q;
  assign rot_o        = rot_q;
  assign sync_o.hs    = (h_q >= HS_START) && (h_q < HS_END);
  assign sync_o.vs    = (v_q >= VS_START) && (v_q < VS_END);
  assign sync_o.blank = (h_q >= HW'(H_ACTIVE)) || (v_q >= VW'(V_ACTIVE));
endmodule

// File: rtl/cell_mapper.sv
module cell_mapper
  import text_raster_pkg::*;
#(
  parameter int HW      = 11,
  parameter int VW      = 10,
  parameter int GLYPH_W = 16,
  parameter int GLYPH_H = 32,
  parameter int COL_W   = 6,
  parameter int ROW_W   = 6,
  parameter bit ROT_EN  = 1'b1,
  localparam int GW_L   = $clog2(GLYPH_W),
  localparam int GH_L   = $clog2(GLYPH_H),
  localparam int ADDR_W = COL_W + ROW_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [HW-1:0]     h_i,
  input  logic [VW-1:0]     v_i,
  input  logic              rot_i,
  input  sync_t             sync_i,
  output logic [ADDR_W-1:0] char_addr_o,
  output logic [GH_L-1:0]   grow_o,
  output logic [GW_L-1:0]   gcol_o,
  output sync_t             sync_o
);
  logic [COL_W-1:0] n_col, col;
  logic [ROW_W-1:0] n_row, row;
  logic [GH_L-1:0]  n_grow, grow;
  logic [GW_L-1:0]  n_gcol, gcol;

  // upright cells: GLYPH_W wide, GLYPH_H tall
  assign n_col  = COL_W'(h_i >> GW_L);
  assign n_row  = ROW_W'(v_i >> GH_L);
  assign n_gcol = h_i[GW_L-1:0];
  assign n_grow = v_i[GH_L-1:0];

  generate
    if (ROT_EN) begin : g_rot
      logic [COL_W-1:0] r_col;
      logic [ROW_W-1:0] r_row;
      // quarter turn left: screen x walks glyph rows, screen y walks columns right to left
      assign r_col = COL_W'(h_i >> GH_L);
      assign r_row = ROW_W'(v_i >> GW_L);
      assign col   = rot_i ? r_col : n_col;
      assign row   = rot_i ? r_row : n_row;
      assign grow  = rot_i ? h_i[GH_L-1:0] : n_grow;
      assign gcol  = rot_i ? ~v_i[GW_L-1:0] : n_gcol;
    end else begin : g_norot
      logic unused_rot;
      assign unused_rot = rot_i;
      assign col  = n_col;
      assign row  = n_row;
      assign grow = n_grow;
      assign gcol = n_gcol;
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      char_addr_o <= '0;
      grow_o      <= '0;
      gcol_o      <= '0;
      sync_o      <= '{hs: 1'b0, vs: 1'b0, blank: 1'b1};
    end else begin
      char_addr_o <= {row, col};
      grow_o      <= grow;
      gcol_o      <= gcol;
      sync_o      <= sync_i;
    end
  end
endmodule

// File: rtl/glyph_pipe.sv
module glyph_pipe
  import text_raster_pkg::*;
#(
  parameter int GLYPH_W = 16,
  parameter int GLYPH_H = 32,
  parameter int CODE_W  = 8,
  parameter int IDX_W   = 4,
  localparam int GW_L   = $clog2(GLYPH_W),
  localparam int GH_L   = $clog2(GLYPH_H),
  localparam int CHAR_W = CODE_W + 2 * IDX_W,
  localparam int GA_W   = CODE_W + GH_L
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [GH_L-1:0]    grow_i,
  input  logic [GW_L-1:0]    gcol_i,
  input  sync_t              sync_i,
  input  logic [CHAR_W-1:0]  char_data_i,
  output logic [GA_W-1:0]    glyph_addr_o,
  input  logic [GLYPH_W-1:0] glyph_data_i,
  output logic [IDX_W-1:0]   idx_o,
  output sync_t              sync_o
);
  localparam logic [GW_L-1:0] MSB_SEL = GW_L'(GLYPH_W - 1);
  localparam sync_t SYNC_RST = '{hs: 1'b0, vs: 1'b0, blank: 1'b1};

  logic [GH_L-1:0]  grow2_q;
  logic [GW_L-1:0]  gcol2_q, gcol3_q, gcol4_q;
  logic [IDX_W-1:0] fg3_q, bg3_q, fg4_q, bg4_q;
  sync_t            sync2_q, sync3_q, sync4_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      grow2_q      <= '0;
      gcol2_q      <= '0;
      gcol3_q      <= '0;
      gcol4_q      <= '0;
      fg3_q        <= '0;
      bg3_q        <= '0;
      fg4_q        <= '0;
      bg4_q        <= '0;
      glyph_addr_o <= '0;
      sync2_q      <= SYNC_RST;
      sync3_q      <= SYNC_RST;
      sync4_q      <= SYNC_RST;
    end else begin
      // stage 2: waiting on character memory
      grow2_q <= grow_i;
      gcol2_q <= gcol_i;
      sync2_q <= sync_i;
      // stage 3: character word present, issue glyph row fetch
      glyph_addr_o <= {char_data_i[CODE_W-1:0], grow2_q};
      fg3_q        <= char_data_i[CODE_W +: IDX_W];
      bg3_q        <= char_data_i[CODE_W + IDX_W +: IDX_W];
      gcol3_q      <= gcol2_q;
      sync3_q      <= sync2_q;
      // stage 4: glyph row present on glyph_data_i
      fg4_q   <= fg3_q;
      bg4_q   <= bg3_q;
      gcol4_q <= gcol3_q;
      sync4_q <= sync3_q;
    end
  end

  assign idx_o  = glyph_data_i[MSB_SEL - gcol4_q] ? fg4_q : bg4_q;
  assign sync_o = sync4_q;
endmodule

// File: rtl/palette_out.sv
module palette_out
  import text_raster_pkg::*;
#(
  parameter int IDX_W   = 4,
  parameter int PAL_W   = 32,
  parameter int COLOR_W = 24,
  localparam int PAL_N  = 1 << IDX_W,
  localparam int LOW_W  = PAL_W - COLOR_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               we_i,
  input  logic [IDX_W-1:0]   waddr_i,
  input  logic [PAL_W-1:0]   wdata_i,
  input  logic [IDX_W-1:0]   idx_i,
  input  sync_t              sync_i,
  output logic               hsync_o,
  output logic               vsync_o,
  output logic               blank_o,
  output logic [COLOR_W-1:0] rgb_o
);
  logic [COLOR_W-1:0] pal_q [PAL_N];
  logic [LOW_W-1:0]   unused_low;

  // only the upper bytes are kept; the low byte is dropped at write
  assign unused_low = wdata_i[LOW_W-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < PAL_N; i++) pal_q[i] <= '0;
    end else if (we_i) begin
      pal_q[waddr_i] <= wdata_i[PAL_W-1:LOW_W];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hsync_o <= 1'b0;
      vsync_o <= 1'b0;
      blank_o <= 1'b1;
      rgb_o   <= '0;
    end else begin
      hsync_o <= sync_i.hs;
      vsync_o <= sync_i.vs;
      blank_o <= sync_i.blank;
      rgb_o   <= sync_i.blank ? '0 : pal_q[idx_i];
    end
  end
endmodule

// File: rtl/text_raster_gen.sv
module text_raster_gen
  import text_raster_pkg::*;
#(
  parameter int H_ACTIVE = 800,
  parameter int H_FP     = 56,
  parameter int H_SYNC   = 120,
  parameter int H_BP     = 64,
  parameter int V_ACTIVE = 600,
  parameter int V_FP     = 37,
  parameter int V_SYNC   = 6,
  parameter int V_BP     = 23,
  parameter int GLYPH_W  = 16,
  parameter int GLYPH_H  = 32,
  parameter int CODE_W   = 8,
  parameter int IDX_W    = 4,
  parameter int COL_W    = 6,
  parameter int ROW_W    = 6,
  parameter int PAL_W    = 32,
  parameter int COLOR_W  = 24,
  parameter bit ROT_EN   = 1'b1,
  localparam int HT      = H_ACTIVE + H_FP + H_SYNC + H_BP,
  localparam int VT      = V_ACTIVE + V_FP + V_SYNC + V_BP,
  localparam int HW      = $clog2(HT),
  localparam int VW      = $clog2(VT),
  localparam int GH_L    = $clog2(GLYPH_H),
  localparam int GW_L    = $clog2(GLYPH_W),
  localparam int ADDR_W  = COL_W + ROW_W,
  localparam int CHAR_W  = CODE_W + 2 * IDX_W,
  localparam int GA_W    = CODE_W + GH_L
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               rotate_i,
  output logic [ADDR_W-1:0]  char_addr_o,
  input  logic [CHAR_W-1:0]  char_data_i,
  output logic [GA_W-1:0]    glyph_addr_o,
  input  logic [GLYPH_W-1:0] glyph_data_i,
  input  logic               pal_we_i,
  input  logic [IDX_W-1:0]   pal_waddr_i,
  input  logic [PAL_W-1:0]   pal_wdata_i,
  output logic               hsync_o,
  output logic               vsync_o,
  output logic               blank_o,
  output logic [COLOR_W-1:0] rgb_o
);
  logic [HW-1:0]    h_w;
  logic [VW-1:0]    v_w;
  logic             rot_w;
  logic             frame_end_w;
  sync_t            sync0_w, sync1_w, sync4_w;
  logic [GH_L-1:0]  grow1_w;
  logic [GW_L-1:0]  gcol1_w;
  logic [IDX_W-1:0] idx4_w;

  raster_timing #(
    .H_ACTIVE(H_ACTIVE), .H_FP(H_FP), .H_SYNC(H_SYNC), .H_BP(H_BP),
    .V_ACTIVE(V_ACTIVE), .V_FP(V_FP), .V_SYNC(V_SYNC), .V_BP(V_BP)
  ) u_timing (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .rotate_i   (rotate_i),
    .h_o        (h_w),
    .v_o        (v_w),
    .sync_o     (sync0_w),
    .rot_o      (rot_w),
    .frame_end_o(frame_end_w)
  );

  cell_mapper #(
    .HW(HW), .VW(VW), .GLYPH_W(GLYPH_W), .GLYPH_H(GLYPH_H),
    .COL_W(COL_W), .ROW_W(ROW_W), .ROT_EN(ROT_EN)
  ) u_map (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .h_i        (h_w),
    .v_i        (v_w),
    .rot_i      (rot_w),
    .sync_i     (sync0_w),
    .char_addr_o(char_addr_o),
    .grow_o     (grow1_w),
    .gcol_o     (gcol1_w),
    .sync_o     (sync1_w)
  );

  glyph_pipe #(
    .GLYPH_W(GLYPH_W), .GLYPH_H(GLYPH_H), .CODE_W(CODE_W), .IDX_W(IDX_W)
  ) u_glyph (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .grow_i      (grow1_w),
    .gcol_i      (gcol1_w),
    .sync_i      (sync1_w),
    .char_data_i (char_data_i),
    .glyph_addr_o(glyph_addr_o),
    .glyph_data_i(glyph_data_i),
    .idx_o       (idx4_w),
    .sync_o      (sync4_w)
  );

  palette_out #(
    .IDX_W(IDX_W), .PAL_W(PAL_W), .COLOR_W(COLOR_W)
  ) u_pal (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (pal_we_i),
    .waddr_i(pal_waddr_i),
    .wdata_i(pal_wdata_i),
    .idx_i  (idx4_w),
    .sync_i (sync4_w),
    .hsync_o(hsync_o),
    .vsync_o(vsync_o),
    .blank_o(blank_o),
    .rgb_o  (rgb_o)
  );
endmodule

// File: rtl/text_raster_chk.sv
module text_raster_chk #(
  parameter int H_SYNC  = 120,
  parameter int COLOR_W = 24
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               hsync_o,
  input logic               vsync_o,
  input logic               blank_o,
  input logic [COLOR_W-1:0] rgb_o,
  input logic               rot_q,
  input logic               frame_end
);
  logic [15:0] hs_len_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) hs_len_q <= '0;
    else         hs_len_q <= hsync_o ? hs_len_q + 16'd1 : '0;
  end

  assert_rgb_dark_in_blank_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    blank_o |-> (rgb_o == '0));

  assert_hsync_in_blank_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hsync_o |-> blank_o);

  assert_vsync_in_blank_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vsync_o |-> blank_o);

  assert_vsync_starts_line_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(vsync_o) |-> !hsync_o);

  assert_hsync_width_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(hsync_o) |-> (hs_len_q == 16'(H_SYNC)));

  assert_rot_held_in_frame_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !frame_end |=> $stable(rot_q));
endmodule

bind text_raster_gen text_raster_chk #(.H_SYNC(H_SYNC), .COLOR_W(COLOR_W)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .hsync_o  (hsync_o),
  .vsync_o  (vsync_o),
  .blank_o  (blank_o),
  .rgb_o    (rgb_o),
  .rot_q    (rot_w),
  .frame_end(frame_end_w)
);

// File: tb/sim_text_raster_gen.sv
module sim_text_raster_gen;
  localparam int HA = 64, HFP = 4, HS = 8, HBP = 4;
  localparam int VA = 64, VFP = 2, VS = 3, VBP = 3;
  localparam int HT = HA + HFP + HS + HBP;
  localparam int VT = VA + VFP + VS + VBP;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        rotate_i = 1'b0;
  logic [11:0] char_addr_o;
  logic [15:0] char_data_i;
  logic [12:0] glyph_addr_o;
  logic [15:0] glyph_data_i;
  logic        pal_we_i = 1'b0;
  logic [3:0]  pal_waddr_i = '0;
  logic [31:0] pal_wdata_i = '0;
  logic        hsync_o, vsync_o, blank_o;
  logic [23:0] rgb_o;

  logic [31:0] pal_model [16];
  int n_checks = 0;
  int n_err = 0;

  always #5 clk = ~clk;

  text_raster_gen #(
    .H_ACTIVE(HA), .H_FP(HFP), .H_SYNC(HS), .H_BP(HBP),
    .V_ACTIVE(VA), .V_FP(VFP), .V_SYNC(VS), .V_BP(VBP)
  ) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .rotate_i(rotate_i),
    .char_addr_o(char_addr_o), .char_data_i(char_data_i),
    .glyph_addr_o(glyph_addr_o), .glyph_data_i(glyph_data_i),
    .pal_we_i(pal_we_i), .pal_waddr_i(pal_waddr_i), .pal_wdata_i(pal_wdata_i),
    .hsync_o(hsync_o), .vsync_o(vsync_o), .blank_o(blank_o), .rgb_o(rgb_o)
  );

  // stimulus memories: contents computed from the address
  function automatic logic [15:0] char_fn(input logic [11:0] a);
    logic [3:0] fg;
    fg = 4'(a[3:0] + a[9:6]);
    return {fg ^ 4'h9, fg, 8'(int'(a) * 7 + 3)};
  endfunction

  function automatic logic [15:0] glyph_fn(input logic [12:0] ga);
    int c, r;
    c = int'(ga[12:5]);
    r = int'(ga[4:0]);
    return 16'((c * 309) ^ (r * 1285) ^ (r << 11));
  endfunction

  always_ff @(posedge clk) begin
    char_data_i  <= char_fn(char_addr_o);
    glyph_data_i <= glyph_fn(glyph_addr_o);
  end

  function automatic logic [23:0] exp_rgb(input int x, input int y, input logic rot);
    int col, row, gr, gc;
    logic [15:0] d, g;
    logic [3:0] idx;
    if (!rot) begin
      col = x / 16; row = y / 32; gc = x % 16; gr = y % 32;
    end else begin
      col = x / 32; row = y / 16; gr = x % 32; gc = 15 - (y % 16);
    end
    d   = char_fn(12'(row * 64 + col));
    g   = glyph_fn({d[7:0], 5'(gr)});
    idx = g[15 - gc] ? d[11:8] : d[15:12];
    return pal_model[idx][31:8];
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic pal_write(input int i, input logic [31:0] w);
    @(negedge clk);
    pal_we_i = 1'b1; pal_waddr_i = 4'(i); pal_wdata_i = w;
    @(negedge clk);
    pal_we_i = 1'b0;
    pal_model[i] = w;
  endtask

  task automatic wait_vsync_rise();
    logic prev;
    prev = vsync_o;
    forever begin
      @(negedge clk);
      if (vsync_o && !prev) break;
      prev = vsync_o;
    end
  endtask

  // checks one whole frame that follows the next vsync
  task automatic scan_frame(input logic rot, input string req);
    int n, vs_n;
    logic [23:0] e;
    bit blank_bad, hs_bad;
    wait_vsync_rise();
    n = 0; vs_n = 1;
    forever begin
      @(negedge clk);
      n++;
      if (vsync_o) vs_n++;
      if (!blank_o || n > 2 * HT * VT) break;
    end
    check(n == (VS + VBP) * HT, "R1 vsync to first pixel", n, (VS + VBP) * HT);
    check(vs_n == VS * HT, "R2 vsync length", vs_n, VS * HT);
    for (int y = 0; y < VA; y++) begin
      for (int x = 0; x < HA; x++) begin
        e = exp_rgb(x, y, rot);
        check(!blank_o && !hsync_o && !vsync_o && rgb_o == e, req, {7'b0, blank_o, rgb_o}, {8'b0, e});
        @(negedge clk);
      end
      blank_bad = 0; hs_bad = 0;
      for (int k = 0; k < HT - HA; k++) begin
        if (!blank_o || rgb_o != 0) blank_bad = 1;
        if (hsync_o != (k >= HFP && k < HFP + HS)) hs_bad = 1;
        @(negedge clk);
      end
      check(!blank_bad, "R3 blank region dark", blank_bad, 0);
      check(!hs_bad, "R2 hsync placement", hs_bad, 0);
    end
    check(blank_o, "R1 frame ends after V_ACTIVE lines", blank_o, 1);
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    check(blank_o && !hsync_o && !vsync_o && rgb_o == 0, "R11 outputs in reset",
          {hsync_o, vsync_o, blank_o, rgb_o}, 32'h0100_0000);
    rst_ni = 1'b1;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (!blank_o) break;
    end
    check(!blank_o && rgb_o == 0, "R11 first pixel after reset, palette zero",
          {blank_o, rgb_o}, 0);
  endtask

  task automatic t_load_palette();
    for (int i = 0; i < 16; i++)
      pal_write(i, {8'(i * 17), 8'(255 - i * 13), 8'(i * 29 + 7), 8'(i * 51 + 3)});
  endtask

  task automatic t_normal();
    scan_frame(1'b0, "R4 R5 R6 R7 R8 normal pixel");
  endtask

  task automatic t_low_byte();
    // low byte only: no visible change; entry 5 gets a new colour
    pal_write(3, {pal_model[3][31:8], 8'hA5});
    pal_write(9, {pal_model[9][31:8], 8'h00});
    pal_write(12, {pal_model[12][31:8], 8'hFF});
    pal_write(5, 32'h123456_77);
    scan_frame(1'b0, "R8 palette low byte and rewrite");
  endtask

  task automatic t_rotate_switch(input logic to_rot);
    fork
      scan_frame(!to_rot, "R10 frame keeps old orientation");
      begin
        wait_vsync_rise();
        forever begin
          @(negedge clk);
          if (!blank_o) break;
        end
        repeat (300) @(negedge clk);
        rotate_i = to_rot;
      end
    join
    scan_frame(to_rot, to_rot ? "R9 R10 rotated pixel" : "R10 upright pixel restored");
  endtask

  initial begin
    #(10 * 150000);
    n_err++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  Result: errors=%0d of %0d checks", n_err, n_checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < 16; i++) pal_model[i] = '0;
    t_reset();
    t_load_palette();
    t_normal();
    t_low_byte();
    t_rotate_switch(1'b1);
    t_rotate_switch(1'b0);
    $display("  Result: errors=%0d of %0d checks", n_err, n_checks);
    $finish;
  end
endmodule